// File: doc/BRIEF.md
# Clocked Access Sequencer for an Asynchronous Static RAM

This block sits between a processor-side request port and a static RAM that has no clock of its own. Every control line the RAM sees is produced from registers on the controller's clock edges. A request carries an operation (read or write), an address and write data. The sequencer accepts it only while idle. It then runs one access of a fixed number of clock cycles.

In the first cycle of an access, only the address and, for a write, the data are presented. Memory enable then rises together with exactly one strobe, write or read, and stays high until the access ends. The address and data do not move from the first cycle until enable has dropped. For a read, the RAM's output is sampled a parameterised number of cycles after enable rose, which covers the access time. The value is returned with a one-cycle completion pulse in the same cycle that the port becomes ready again.

Top module: `sram_seq`

## Requirements
- R1: After reset, `ready_o` is 1 and `mem_en_o`, `mem_we_o`, `mem_oe_o` and `done_o` are 0.
- R2: A request is taken on a rising edge where `req_valid_i` and `ready_o` are both 1. `ready_o` is 0 for the whole access. Requests presented while `ready_o` is 0 are ignored and leave the RAM contents unchanged.
- R3: In the first cycle of an access (CYCLE_EDGES cycles in total), `mem_addr_o` already carries the request address while `mem_en_o` is still 0. `mem_en_o` rises only in the second cycle.
- R4: `mem_addr_o` and, for writes, `mem_wdata_o` stay unchanged from the first cycle of the access until `mem_en_o` has fallen.
- R5: `mem_en_o` is 1 for exactly CYCLE_EDGES-1 consecutive cycles. In the cycle after the last one, `mem_en_o` is 0 and `ready_o` is 1 again.
- R6: For a write (`req_we_i`=1), `mem_we_o` equals `mem_en_o` and `mem_oe_o` stays 0, so the RAM ends up holding the write data at that address.
- R7: For a read (`req_we_i`=0), `mem_oe_o` equals `mem_en_o` and `mem_we_o` stays 0. `mem_rdata_i` is sampled at the rising edge that closes the ACCESS_CYC-th cycle with enable high. In the cycle in which `ready_o` returns, `rdata_o` shows that value and `done_o` is 1, for exactly one cycle.
- R8: `mem_we_o` and `mem_oe_o` are never 1 together, and neither is 1 while `mem_en_o` is 0.
- R9: A write completes with `done_o` kept at 0 and `rdata_o` left at the previous read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Request word address |
| req_wdata_i | input | DATA_W | Request write data |
| ready_o | output | 1 | Idle, can take a request |
| done_o | output | 1 | One-cycle pulse with returned read data |
| rdata_o | output | DATA_W | Last read result |
| mem_addr_o | output | ADDR_W | RAM address lines |
| mem_wdata_o | output | DATA_W | RAM data-input lines |
| mem_rdata_i | input | DATA_W | RAM data-output lines |
| mem_en_o | output | 1 | RAM memory enable |
| mem_we_o | output | 1 | RAM write strobe |
| mem_oe_o | output | 1 | RAM read strobe |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of an access. If it leaked through, it would corrupt a word silently, and nothing would show until that word was read later. The bench raises a conflicting write to the neighbouring address while `ready_o` is low and drops it before the port is idle again. A full read sweep afterwards shows that no such word was changed. The behavioural RAM model returns the complement of the stored word whenever its read strobe is off, so a sample taken outside the read window shows up as a data mismatch.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic {OP_READ = 1'b0, OP_WRITE = 1'b1} op_e;
endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CYCLE_EDGES = 3,
  localparam int PH_W = (CYCLE_EDGES > 1) ? $clog2(CYCLE_EDGES) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            busy_o,
  output logic [PH_W-1:0] phase_o,
  output logic            last_o
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYCLE_EDGES - 1);

  logic            busy_q;
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        ph_q   <= '0;
      end
    end else if (ph_q == LAST_PH) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign phase_o = ph_q;
  assign last_o  = busy_q && (ph_q == LAST_PH);
endmodule

// File: rtl/sram_seq_req_reg.sv
module sram_seq_req_reg
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o    <= OP_READ;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      op_o    <= we_i ? OP_WRITE : OP_READ;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/sram_seq_rd_cap.sv
module sram_seq_rd_cap #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              finish_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (capture_i) hold_q <= mem_rdata_i;
      if (finish_i)  rdata_o <= capture_i ? mem_rdata_i : hold_q;
    end
  end
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int CYCLE_EDGES = 3,
  parameter int ACCESS_CYC  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic              mem_oe_o
);
  localparam int PH_W = (CYCLE_EDGES > 1) ? $clog2(CYCLE_EDGES) : 1;
  localparam logic [PH_W-1:0] SAMPLE_PH = PH_W'(ACCESS_CYC);

  generate
    if (CYCLE_EDGES < 2 || ACCESS_CYC < 1 || ACCESS_CYC > CYCLE_EDGES - 1) begin : g_bad_cfg
      $error("sram_seq: need CYCLE_EDGES >= 2 and 1 <= ACCESS_CYC <= CYCLE_EDGES-1");
    end
  endgenerate

  logic            busy, last, accept, capture, finish, enable;
  logic [PH_W-1:0] phase;
  op_e             op;

  assign accept = req_valid_i && !busy;

  sram_seq_timer #(.CYCLE_EDGES(CYCLE_EDGES)) timer_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .busy_o  (busy),
    .phase_o (phase),
    .last_o  (last)
  );

  sram_seq_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) req_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .we_i    (req_we_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .op_o    (op),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );

  // phase 0 is address setup; enable covers the remaining phases
  assign enable  = busy && (phase != '0);
  assign capture = enable && (op == OP_READ) && (phase == SAMPLE_PH);
  assign finish  = last && (op == OP_READ);

  sram_seq_rd_cap #(.DATA_W(DATA_W)) cap_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .capture_i   (capture),
    .finish_i    (finish),
    .mem_rdata_i (mem_rdata_i),
    .rdata_o     (rdata_o),
    .done_o      (done_o)
  );

  assign ready_o  = !busy;
  assign mem_en_o = enable;
  assign mem_we_o = enable && (op == OP_WRITE);
  assign mem_oe_o = enable && (op == OP_READ);
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic              mem_oe_o
);
  // R8
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_oe_o));

  // R8
  strobe_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_oe_o) |-> mem_en_o);

  // R3
  addr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_en_o) |-> ($stable(mem_addr_o) && !$past(ready_o)));

  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && $past(mem_en_o)) |-> ($stable(mem_addr_o) && $stable(mem_wdata_o)));

  // R2
  busy_while_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> !ready_o);

  // R5
  en_fall_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_en_o) |-> ready_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ready_o && $fell(mem_oe_o)));
endmodule

bind sram_seq sram_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_en_o    (mem_en_o),
  .mem_we_o    (mem_we_o),
  .mem_oe_o    (mem_oe_o)
);

// File: tb/sram_seq_tb_top.sv
module sram_seq_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int CE = 3;
  localparam int AC = 1;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          ready, done, m_en, m_we, m_oe;
  logic [DW-1:0] rdata, m_wdata, m_rdata;
  logic [AW-1:0] m_addr;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] ram [WORDS];
  logic [DW-1:0] ref_mem [WORDS];
  logic [DW-1:0] last_rd = '0;

  always #5 clk = ~clk;

  sram_seq #(.ADDR_W(AW), .DATA_W(DW), .CYCLE_EDGES(CE), .ACCESS_CYC(AC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .mem_addr_o(m_addr), .mem_wdata_o(m_wdata), .mem_rdata_i(m_rdata),
    .mem_en_o(m_en), .mem_we_o(m_we), .mem_oe_o(m_oe)
  );

  // unclocked RAM model: latches on the falling write strobe, junk when not reading
  always @(negedge m_we) ram[m_addr] = m_wdata;
  assign m_rdata = (m_en && m_oe) ? ram[m_addr] : ~ram[m_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit inject);
    @(negedge clk);
    chk(ready == 1'b1, "R2 ready before request", int'(ready), 1);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i <= CE; i++) begin
      if (i > 0) @(negedge clk);
      if (inject && i == 1) begin
        req_valid = 1'b1; req_we = 1'b1; req_addr = a + 1'b1; req_wdata = ~ref_mem[a + 1'b1];
      end
      if (inject && i == 2) req_valid = 1'b0;
      if (i < CE) begin
        chk(ready == 1'b0, "R2 busy during access", int'(ready), 0);
        chk(m_addr == a, "R3 R4 address held", int'(m_addr), int'(a));
        if (we) chk(m_wdata == d, "R4 write data held", int'(m_wdata), int'(d));
        chk(m_en == (i != 0), "R3 R5 enable timing", int'(m_en), int'(i != 0));
        chk(m_we == (we && i != 0), "R6 write strobe", int'(m_we), int'(we && i != 0));
        chk(m_oe == (!we && i != 0), "R7 read strobe", int'(m_oe), int'(!we && i != 0));
      end else begin
        chk(m_en == 1'b0 && ready == 1'b1, "R5 end of access", int'({m_en, ready}), 1);
        chk(done == !we, "R7 R9 done pulse", int'(done), int'(!we));
        if (we) begin
          chk(rdata == last_rd, "R9 rdata kept on write", int'(rdata), int'(last_rd));
          ref_mem[a] = d;
        end else begin
          chk(rdata == ref_mem[a], "R7 read data", int'(rdata), int'(ref_mem[a]));
          last_rd = ref_mem[a];
        end
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R7 done lasts one cycle", int'(done), 0);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      ram[i] = '0;
      ref_mem[i] = '0;
    end
    #23;
    chk(ready == 1'b1, "R1 reset ready", int'(ready), 1);
    chk({m_en, m_we, m_oe, done} == 4'b0, "R1 reset strobes", int'({m_en, m_we, m_oe, done}), 0);
    rst_n = 1'b1;
    for (int a = 0; a < WORDS; a++) access(1'b1, AW'(a), DW'(a * 37 + 11), 1'b0);
    for (int a = 0; a < WORDS; a++) access(1'b0, AW'(a), 'x, 1'b0);
    // second pattern, with ignored mid-access requests aimed at the neighbour
    for (int a = WORDS - 1; a >= 0; a--) access(1'b1, AW'(a), DW'(a) ^ 8'hC3, 1'b1);
    for (int a = 0; a < WORDS; a++) access(1'b0, AW'(a), '0, 1'b1);
    for (int a = 0; a < WORDS; a++) begin
      access(1'b1, AW'(a), DW'(255 - a * 13), 1'b0);
      access(1'b0, AW'(a), '0, 1'b0);
    end
    for (int a = 0; a < WORDS; a++)
      chk(ram[a] == ref_mem[a], "R2 R6 RAM contents", int'(ram[a]), int'(ref_mem[a]));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule